// File: doc/BRIEF.md
# Encoder Startup Configuration Sequencer

This controller brings an optical encoder interface chip out of power-up. When the power-good input rises, it programs the chip's register RAM through a single-transaction register port. The port carries a request/acknowledge handshake with address, write data, read data and a write enable. The SPI shifting sits behind that port and is not part of this block. Every configuration byte comes from a table held in a parameter. The default contents of the table equal the chip's own power-on register values.

The sequence branches on two mode inputs, which are latched at the power-good edge. Without the fine counter, the block writes the interpolator resolution, enables the interpolator, releases the A/B/Z outputs and finishes. With the fine counter, it writes the counter parameter range with the output tri-state bit forced, arms the counter control register and then starts the counter. It then reads the status register until the position-valid flag is set. Only after that does it enable the A/B/Z outputs, by a method that depends on the output mode.

A poll limit stops a chip that never reports a valid position. When the limit is reached the block raises an error flag and leaves the outputs disabled.

Top module: `enc_cfg_seq`

## Requirements
- R1: While rst_ni is low and after reset, req_o, busy_o, done_o and err_o are 0.
- R2: A sequence starts only on a 0-to-1 transition of pgood_i. A level held high after a finished sequence issues no request.
- R3: Each sequence first writes addresses 0x00 to 0x09 in ascending order with the table bytes. The default table holds 0xA0 at 0x00 and 0x01, 0xC0 at 0x02 to 0x05, 0x60 at 0x06, 0x09 at 0x07, 0x18 at 0x08, 0x8E at 0x0B, 0xA0 at 0x11, and 0x00 at all other entries.
- R4: With fine_en_i = 0 the next writes are, in order: 0x0E with its table byte; 0x11 with the interpolator-enable bit (default bit 4) set; 0x0B with the tri-state bit (default bit 7) cleared. The sequence then completes.
- R5: With fine_en_i = 1 the next writes cover addresses 0x0A to 0x10 in order with their table bytes. At 0x0B the tri-state bit is forced to tri_mode_i.
- R6: On the counter path, address 0x11 is then written twice. The first write sets interpolator-enable and sub-reset (default bit 3) and sets output-low-release (default bit 6) equal to tri_mode_i. The second write repeats the first with the counter-stop bit (default bit 5) and sub-reset cleared.
- R7: On the counter path, the block then reads address 0x12 repeatedly until bit POSOK_BIT (default bit 0) of the read data is 1. All other read-data bits are ignored.
- R8: Once the position is valid, the outputs are enabled with one write. With tri_mode_i = 1 it writes 0x0B with the table byte and the tri-state bit cleared. With tri_mode_i = 0 it writes 0x11 with the second control byte of R6 plus output-low-release set. The sequence then completes.
- R9: If POLL_LIMIT reads of 0x12 all return position-valid 0, err_o rises at the last acknowledge. No further request follows and the outputs are never enabled.
- R10: At most one transaction is outstanding. While req_o is high without ack_i, addr_o, we_o and wdata_o stay unchanged. req_o falls in the cycle after an acknowledge.
- R11: busy_o is high from the cycle after the pgood_i rise until completion or error. done_o rises at the final acknowledge. done_o and err_o then stay high until the next pgood_i rise, which clears them.
- R12: A pgood_i rise while a request is outstanding lets that request finish its handshake. The sequence then restarts from address 0x00 with the newly latched modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pgood_i | input | 1 | Power-good indication, synchronous to clk_i |
| fine_en_i | input | 1 | 1 selects the fine-counter path, latched at the pgood_i rise |
| tri_mode_i | input | 1 | Counter path: 1 tri-state outputs, 0 driven-low outputs; latched at the rise |
| req_o | output | 1 | Transaction request |
| ack_i | input | 1 | Transaction acknowledge |
| we_o | output | 1 | 1 write, 0 read |
| addr_o | output | ADDR_W | Register address |
| wdata_o | output | 8 | Write data |
| rdata_i | input | 8 | Read data, valid with ack_i on a read |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed (sticky) |
| err_o | output | 1 | Position-valid poll timed out (sticky) |

## Verification
The bench builds the block with POLL_LIMIT set to 4 and keeps the default table, register addresses and bit positions. The small limit makes the timeout path reachable after four failed reads, while other runs reach the position-valid flag after zero or two failed reads. Acknowledge latency varies from zero to two cycles and can be held off entirely. Holding it off lets a power-good rise land on an outstanding request, which exercises the deferred restart.

// File: rtl/enc_cfg_pkg.sv
package enc_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BASE,
    ST_RANGE,
    ST_RES,
    ST_IPO,
    ST_TRI_CLR,
    ST_ARM,
    ST_RUN,
    ST_POLL,
    ST_OUT
  } seq_state_e;

  function automatic logic [7:0] put_bit(input logic [7:0] v, input logic [2:0] pos,
                                         input logic b);
    logic [7:0] r;
    r = v;
    r[pos] = b;
    return r;
  endfunction

endpackage

// File: rtl/enc_pg_rise.sv
module enc_pg_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pgood_i,
  output logic rise_o
);
  logic pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= 1'b0;
    else         pg_q <= pgood_i;
  end

  assign rise_o = pgood_i & ~pg_q;
endmodule

// File: rtl/enc_cfg_xact.sv
module enc_cfg_xact #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              cmpl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (req_o) begin
      if (ack_i) req_o <= 1'b0;
    end else if (issue_i) begin
      req_o   <= 1'b1;
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  assign cmpl_o = req_o & ack_i;
endmodule

// File: rtl/enc_poll_timer.sv
module enc_poll_timer #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_V);
endmodule

// File: rtl/enc_cfg_fsm.sv
module enc_cfg_fsm
  import enc_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned N_REGS      = 18,
  parameter logic [N_REGS*8-1:0] CFG_TABLE = '0,
  parameter int unsigned BASE_LAST   = 9,
  parameter int unsigned RANGE_FIRST = 10,
  parameter int unsigned RANGE_LAST  = 16,
  parameter int unsigned RES_ADDR    = 14,
  parameter int unsigned OE_ADDR     = 11,
  parameter int unsigned CTL_ADDR    = 17,
  parameter int unsigned STAT_ADDR   = 18,
  parameter int unsigned TRI_BIT     = 7,
  parameter int unsigned OUTLO_BIT   = 6,
  parameter int unsigned STOP_BIT    = 5,
  parameter int unsigned IPO_BIT     = 4,
  parameter int unsigned SUBRST_BIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fine_en_i,
  input  logic              tri_mode_i,
  input  logic              xact_busy_i,
  input  logic              cmpl_i,
  input  logic              posok_i,
  input  logic              tmo_last_i,
  output logic              issue_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              tmo_clr_o,
  output logic              tmo_inc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] BASE_LAST_A   = ADDR_W'(BASE_LAST);
  localparam logic [ADDR_W-1:0] RANGE_FIRST_A = ADDR_W'(RANGE_FIRST);
  localparam logic [ADDR_W-1:0] RANGE_LAST_A  = ADDR_W'(RANGE_LAST);
  localparam logic [ADDR_W-1:0] RES_A         = ADDR_W'(RES_ADDR);
  localparam logic [ADDR_W-1:0] OE_A          = ADDR_W'(OE_ADDR);
  localparam logic [ADDR_W-1:0] CTL_A         = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A        = ADDR_W'(STAT_ADDR);
  localparam logic [2:0] TRI_P   = 3'(TRI_BIT);
  localparam logic [2:0] OUTLO_P = 3'(OUTLO_BIT);
  localparam logic [2:0] STOP_P  = 3'(STOP_BIT);
  localparam logic [2:0] IPO_P   = 3'(IPO_BIT);
  localparam logic [2:0] SUB_P   = 3'(SUBRST_BIT);

  localparam logic [7:0] CTL_TBL = CFG_TABLE[CTL_ADDR*8 +: 8];
  localparam logic [7:0] OE_TBL  = CFG_TABLE[OE_ADDR*8 +: 8];
  localparam logic [7:0] RES_TBL = CFG_TABLE[RES_ADDR*8 +: 8];
  localparam logic [7:0] IPO_VAL = put_bit(CTL_TBL, IPO_P, 1'b1);
  localparam logic [7:0] OE_REL  = put_bit(OE_TBL, TRI_P, 1'b0);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] idx_q;
  logic              pend_q;
  logic              fine_q;
  logic              tri_q;

  logic [7:0] arm_val;
  logic [7:0] run_val;
  logic [7:0] idx_byte;

  function automatic logic [7:0] tbl_byte(input logic [ADDR_W-1:0] a);
    return CFG_TABLE[int'(a)*8 +: 8];
  endfunction

  assign arm_val  = put_bit(put_bit(IPO_VAL, SUB_P, 1'b1), OUTLO_P, tri_q);
  assign run_val  = put_bit(put_bit(arm_val, STOP_P, 1'b0), SUB_P, 1'b0);
  assign idx_byte = tbl_byte(idx_q);

  always_comb begin
    we_o    = 1'b1;
    addr_o  = idx_q;
    wdata_o = idx_byte;
    unique case (state_q)
      ST_BASE: ;
      ST_RANGE: if (idx_q == OE_A) wdata_o = put_bit(idx_byte, TRI_P, tri_q);
      ST_RES: begin
        addr_o  = RES_A;
        wdata_o = RES_TBL;
      end
      ST_IPO: begin
        addr_o  = CTL_A;
        wdata_o = IPO_VAL;
      end
      ST_TRI_CLR: begin
        addr_o  = OE_A;
        wdata_o = OE_REL;
      end
      ST_ARM: begin
        addr_o  = CTL_A;
        wdata_o = arm_val;
      end
      ST_RUN: begin
        addr_o  = CTL_A;
        wdata_o = run_val;
      end
      ST_POLL: begin
        we_o    = 1'b0;
        addr_o  = STAT_A;
        wdata_o = '0;
      end
      ST_OUT: begin
        addr_o  = tri_q ? OE_A : CTL_A;
        wdata_o = tri_q ? OE_REL : put_bit(run_val, OUTLO_P, 1'b1);
      end
      default: begin
        we_o    = 1'b0;
        wdata_o = '0;
      end
    endcase
  end

  assign issue_o   = (state_q != ST_IDLE) && !xact_busy_i && !pend_q;
  assign tmo_clr_o = cmpl_i && (state_q == ST_RUN);
  assign tmo_inc_o = cmpl_i && (state_q == ST_POLL) && !posok_i && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      fine_q  <= 1'b0;
      tri_q   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (cmpl_i) begin
        if (pend_q) begin
          state_q <= ST_BASE;
          idx_q   <= '0;
          pend_q  <= 1'b0;
        end else begin
          unique case (state_q)
            ST_BASE: begin
              if (idx_q == BASE_LAST_A) begin
                if (fine_q) begin
                  state_q <= ST_RANGE;
                  idx_q   <= RANGE_FIRST_A;
                end else begin
                  state_q <= ST_RES;
                end
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            ST_RANGE: begin
              if (idx_q == RANGE_LAST_A) state_q <= ST_ARM;
              else                       idx_q   <= idx_q + 1'b1;
            end
            ST_RES:     state_q <= ST_IPO;
            ST_IPO:     state_q <= ST_TRI_CLR;
            ST_ARM:     state_q <= ST_RUN;
            ST_RUN:     state_q <= ST_POLL;
            ST_POLL: begin
              if (posok_i) begin
                state_q <= ST_OUT;
              end else if (tmo_last_i) begin
                state_q <= ST_IDLE;
                busy_o  <= 1'b0;
                err_o   <= 1'b1;
              end
            end
            ST_TRI_CLR, ST_OUT: begin
              state_q <= ST_IDLE;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
      if (rise_i) begin
        busy_o <= 1'b1;
        done_o <= 1'b0;
        err_o  <= 1'b0;
        fine_q <= fine_en_i;
        tri_q  <= tri_mode_i;
        if (xact_busy_i && !cmpl_i) begin
          pend_q <= 1'b1;  // let the open handshake finish first
        end else begin
          state_q <= ST_BASE;
          idx_q   <= '0;
          pend_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/enc_cfg_seq.sv
module enc_cfg_seq #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned N_REGS      = 18,
  parameter logic [N_REGS*8-1:0] CFG_TABLE =
    144'hA0_00_00_00_00_00_8E_00_00_18_09_60_C0_C0_C0_C0_A0_A0,
  parameter int unsigned BASE_LAST   = 9,
  parameter int unsigned RANGE_FIRST = 10,
  parameter int unsigned RANGE_LAST  = 16,
  parameter int unsigned RES_ADDR    = 14,
  parameter int unsigned OE_ADDR     = 11,
  parameter int unsigned CTL_ADDR    = 17,
  parameter int unsigned STAT_ADDR   = 18,
  parameter int unsigned TRI_BIT     = 7,
  parameter int unsigned OUTLO_BIT   = 6,
  parameter int unsigned STOP_BIT    = 5,
  parameter int unsigned IPO_BIT     = 4,
  parameter int unsigned SUBRST_BIT  = 3,
  parameter int unsigned POSOK_BIT   = 0,
  parameter int unsigned POLL_LIMIT  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgood_i,
  input  logic              fine_en_i,
  input  logic              tri_mode_i,
  output logic              req_o,
  input  logic              ack_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  input  logic [7:0]        rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [2:0] POSOK_P = 3'(POSOK_BIT);

  logic              pg_rise;
  logic              issue;
  logic              cmpl;
  logic              nx_we;
  logic [ADDR_W-1:0] nx_addr;
  logic [7:0]        nx_wdata;
  logic              tmo_clr;
  logic              tmo_inc;
  logic              tmo_last;
  logic              posok;
  logic              unused_rdata;

  assign posok        = rdata_i[POSOK_P];
  assign unused_rdata = ^rdata_i;

  enc_pg_rise u_rise (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pgood_i (pgood_i),
    .rise_o  (pg_rise)
  );

  enc_cfg_fsm #(
    .ADDR_W      (ADDR_W),
    .N_REGS      (N_REGS),
    .CFG_TABLE   (CFG_TABLE),
    .BASE_LAST   (BASE_LAST),
    .RANGE_FIRST (RANGE_FIRST),
    .RANGE_LAST  (RANGE_LAST),
    .RES_ADDR    (RES_ADDR),
    .OE_ADDR     (OE_ADDR),
    .CTL_ADDR    (CTL_ADDR),
    .STAT_ADDR   (STAT_ADDR),
    .TRI_BIT     (TRI_BIT),
    .OUTLO_BIT   (OUTLO_BIT),
    .STOP_BIT    (STOP_BIT),
    .IPO_BIT     (IPO_BIT),
    .SUBRST_BIT  (SUBRST_BIT)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (pg_rise),
    .fine_en_i   (fine_en_i),
    .tri_mode_i  (tri_mode_i),
    .xact_busy_i (req_o),
    .cmpl_i      (cmpl),
    .posok_i     (posok),
    .tmo_last_i  (tmo_last),
    .issue_o     (issue),
    .we_o        (nx_we),
    .addr_o      (nx_addr),
    .wdata_o     (nx_wdata),
    .tmo_clr_o   (tmo_clr),
    .tmo_inc_o   (tmo_inc),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  enc_cfg_xact #(.ADDR_W(ADDR_W)) u_xact (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .we_i    (nx_we),
    .addr_i  (nx_addr),
    .wdata_i (nx_wdata),
    .ack_i   (ack_i),
    .req_o   (req_o),
    .we_o    (we_o),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .cmpl_o  (cmpl)
  );

  enc_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmo_clr),
    .inc_i  (tmo_inc),
    .last_o (tmo_last)
  );
endmodule

// File: rtl/enc_cfg_seq_chk.sv
module enc_cfg_seq_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pg_rise_i,
  input logic              req_i,
  input logic              ack_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              err_i
);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_i |=> req_i && $stable(addr_i) && $stable(we_i) && $stable(wdata_i));

  assert_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ack_i |=> !req_i);

  assert_req_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> busy_i);

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && (done_i || err_i)) && !(done_i && err_i));

  assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !pg_rise_i |=> done_i);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !pg_rise_i |=> err_i);

  assert_err_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $past(req_i && ack_i && !we_i));

  assert_start_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(pg_rise_i));
endmodule

bind enc_cfg_seq enc_cfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pg_rise_i (pg_rise),
  .req_i     (req_o),
  .ack_i     (ack_i),
  .we_i      (we_o),
  .addr_i    (addr_o),
  .wdata_i   (wdata_o),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .err_i     (err_o)
);

// File: tb/sim_enc_cfg_seq.sv
module sim_enc_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 4;
  localparam int TRI   = 7, OUTLO = 6, STOP = 5, IPO = 4, SUB = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pgood_i = 1'b0;
  logic       fine_en_i = 1'b0;
  logic       tri_mode_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [7:0] rdata_i = 8'h00;
  logic       req_o, we_o, busy_o, done_o, err_o;
  logic [7:0] addr_o, wdata_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  enc_cfg_seq #(.POLL_LIMIT(TMO)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pgood_i(pgood_i), .fine_en_i(fine_en_i),
    .tri_mode_i(tri_mode_i), .req_o(req_o), .ack_i(ack_i), .we_o(we_o),
    .addr_o(addr_o), .wdata_o(wdata_o), .rdata_i(rdata_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  // stimulus knobs
  bit pg_next = 0, pg_cur = 0, fine_drv = 0, tri_drv = 0;
  bit hold_ack = 0, idle_watch = 0;
  int ack_delay = 0, ack_cnt = 0, polls_left = 0;

  // reference model state
  bit exp_busy = 0, exp_done = 0, exp_err = 0, pend = 0, m_fine = 0, m_tri = 0;
  int polls_done = 0;
  int    q_addr[$];
  int    q_data[$];
  bit    q_we[$];
  string q_tag[$];

  function automatic int tb(input int a);
    case (a)
      0, 1, 17:      return 'hA0;
      2, 3, 4, 5:    return 'hC0;
      6:             return 'h60;
      7:             return 'h09;
      8:             return 'h18;
      11:            return 'h8E;
      default:       return 'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input int a, input int d, input bit w, input string t);
    q_addr.push_back(a); q_data.push_back(d); q_we.push_back(w); q_tag.push_back(t);
  endtask

  task automatic rebuild();
    int arm, run, d;
    q_addr.delete(); q_data.delete(); q_we.delete(); q_tag.delete();
    polls_done = 0;
    for (int a = 0; a <= 9; a++) push(a, tb(a), 1, "R3");
    if (!m_fine) begin
      push('h0E, tb('h0E), 1, "R4");
      push('h11, tb('h11) | (1 << IPO), 1, "R4");
      push('h0B, tb('h0B) & ~(1 << TRI), 1, "R4");
    end else begin
      for (int a = 10; a <= 16; a++) begin
        d = tb(a);
        if (a == 11) d = m_tri ? (d | (1 << TRI)) : (d & ~(1 << TRI));
        push(a, d, 1, "R5");
      end
      arm = tb('h11) | (1 << IPO) | (1 << SUB);
      arm = m_tri ? (arm | (1 << OUTLO)) : (arm & ~(1 << OUTLO));
      run = arm & ~(1 << STOP) & ~(1 << SUB);
      push('h11, arm, 1, "R6");
      push('h11, run, 1, "R6");
      push('h12, 0, 0, "R7");
      if (m_tri) push('h0B, tb('h0B) & ~(1 << TRI), 1, "R8");
      else       push('h11, run | (1 << OUTLO), 1, "R8");
    end
  endtask

  task automatic tick();
    bit ack, rise, is_poll;
    logic [7:0] rd;
    @(negedge clk_i);
    chk("R11", "busy", busy_o, exp_busy);
    chk("R11", "done", done_o, exp_done);
    chk("R9", "err", err_o, exp_err);
    if (idle_watch) chk("R2", "req while level held", req_o, 0);
    ack = 0; rd = 8'h00;
    if (req_o && !hold_ack) begin
      if (ack_cnt >= ack_delay) begin ack = 1; ack_cnt = 0; end
      else ack_cnt++;
    end
    if (ack && !we_o && addr_o == 8'h12) begin
      if (polls_left > 0) begin rd = 8'hFE; polls_left--; end  // only bit 0 low
      else rd = 8'h81;
    end
    if (req_o && ack) begin
      if (q_addr.size() == 0) begin
        chk("R10", "unexpected transaction", 1, 0);
      end else begin
        chk(q_tag[0], "addr", addr_o, q_addr[0]);
        chk(q_tag[0], "we", we_o, q_we[0]);
        if (q_we[0]) chk(q_tag[0], "wdata", wdata_o, q_data[0]);
        is_poll = !q_we[0] && q_addr[0] == 'h12;
        void'(q_addr.pop_front()); void'(q_data.pop_front());
        void'(q_we.pop_front()); void'(q_tag.pop_front());
        if (pend) begin
          rebuild(); pend = 0;
        end else if (is_poll && !rd[0]) begin
          polls_done++;
          if (polls_done == TMO) begin
            exp_err = 1; exp_busy = 0;
            q_addr.delete(); q_data.delete(); q_we.delete(); q_tag.delete();
          end else begin
            q_addr.push_front('h12); q_data.push_front(0);
            q_we.push_front(0); q_tag.push_front("R7");
          end
        end else if (q_addr.size() == 0) begin
          exp_done = 1; exp_busy = 0;
        end
      end
    end else if (req_o && q_addr.size() == 0 && !pend) begin
      chk("R2", "request with nothing due", 1, 0);
    end
    rise = pg_next && !pg_cur;
    if (rise && rst_ni) begin
      exp_busy = 1; exp_done = 0; exp_err = 0;
      m_fine = fine_drv; m_tri = tri_drv;
      if (req_o && !ack) pend = 1;
      else begin rebuild(); pend = 0; end
    end
    ack_i = ack; rdata_i = rd; pgood_i = pg_next;
    fine_en_i = fine_drv; tri_mode_i = tri_drv; pg_cur = pg_next;
  endtask

  task automatic run_done();
    int g = 0;
    while ((exp_busy || pend) && g < 3000) begin tick(); g++; end
    if (g >= 3000) chk("R11", "sequence never ended", 1, 0);
    tick(); tick();
  endtask

  task automatic start(input bit f, input bit t);
    fine_drv = f; tri_drv = t;
    pg_next = 0; tick(); tick();
    pg_next = 1; tick();
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      tick();
      chk("R1", "req in reset", req_o, 0);
    end
    rst_ni = 1'b1;
    tick();
    chk("R1", "req after reset", req_o, 0);

    // R3 R4 R13 defaults, no fine counter, 1-cycle ack latency
    ack_delay = 1;
    start(0, 0);
    run_done();
    chk("R4", "done after plain path", done_o, 1);

    // R2: level held high issues nothing
    idle_watch = 1;
    repeat (12) tick();
    idle_watch = 0;
    chk("R11", "done still set", done_o, 1);

    // R5 R6 R7 R8: counter path, tri-state, two failed polls
    ack_delay = 0; polls_left = 2;
    start(1, 1);
    run_done();
    chk("R8", "done tri-state path", done_o, 1);

    // counter path, driven-low, valid at first read, slow ack
    ack_delay = 2; polls_left = 0;
    start(1, 0);
    run_done();
    chk("R8", "done driven-low path", done_o, 1);

    // R9: timeout
    ack_delay = 0; polls_left = 100;
    start(1, 1);
    run_done();
    chk("R9", "err after timeout", err_o, 1);
    chk("R9", "no done after timeout", done_o, 0);
    polls_left = 0;

    // R12: rise while a request is outstanding
    ack_delay = 0;
    start(0, 0);
    repeat (7) tick();
    hold_ack = 1;
    repeat (3) tick();
    chk("R12", "request outstanding", req_o, 1);
    fine_drv = 1; tri_drv = 0;
    pg_next = 0; tick();
    pg_next = 1; tick();
    tick();
    chk("R12", "request still held", req_o, 1);
    hold_ack = 0;
    run_done();
    chk("R12", "done after restart", done_o, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule